// File: doc/BRIEF.md
# PWM Audio Sample Controller

This block turns a stream of 16-bit signed audio samples, written one at a time by a processor through a 32-bit register, into a single pulse-width-modulated output pin. It plays samples at a fixed rate set by a cycle-count parameter; the default of 10000 clocks gives an 8 kHz rate from an 80 MHz clock. Each sample period takes the queued sample into the player and then signals, through an interrupt, that room exists for the next one. If software falls behind, the last sample keeps playing.

The same register also drives two control pins of an external amplifier: a gain select and an active-low shutdown. A write always queues a sample. When bit 16 of that write is set, the write also loads both amplifier pins. Reading the register returns the amplifier pin states, the ready flag in bit 16 and the last written sample.

Top module: `pwm_audio_ctl`

## Requirements
- R1: After reset the read data is 0x00010000: ready set, gain 0, shutdown pin low (amplifier off), sample 0. The interrupt is high and both amplifier pins are low.
- R2: A sample period ends once every CYCLES_PER_SAMPLE clocks. If the interrupt is answered by a write one cycle after it rises, it rises again exactly CYCLES_PER_SAMPLE cycles after that rise.
- R3: Any write queues bits 15:0 as the next sample. The interrupt reads low in the cycle after the write and stays low until the next period boundary.
- R4: Read bit 16 is 1 exactly when the interrupt is high. Read bits 15:0 return the last written sample, and read bits 21 and 20 return the shutdown and gain pin levels. All other read bits are 0.
- R5: A write with bit 16 set loads the shutdown pin from bit 21 and the gain pin from bit 20. Writing 0x00310000 turns the amplifier on with gain 1, and writing 0x00010000 turns it off with gain 0.
- R6: A write with bit 16 clear leaves both amplifier pins unchanged, whatever bits 21 and 20 hold.
- R7: Within a sample period, every run of 2^PWM_W consecutive clocks has the PWM pin high for L clocks. L is the top PWM_W bits of the playing sample with its sign bit inverted (offset binary).
- R8: If no sample is queued when a period ends, the previous sample keeps playing and the interrupt stays high until a write arrives.
- R9: If two writes land in one period, only the second is played in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_wr | input | 1 | Register write strobe, one cycle per write |
| i_wdata | input | 32 | Register write data |
| o_rdata | output | 32 | Register read data (combinational) |
| o_irq | output | 1 | Ready-for-sample interrupt |
| o_pwm | output | 1 | PWM audio output |
| o_gain | output | 1 | Amplifier gain select |
| o_shutdown_n | output | 1 | Amplifier shutdown, low turns it off |

## Verification
The bench is built with a 3-bit carrier and a 40-cycle period. It sweeps all eight duty levels, using samples of both signs with varied low bits, so that a sign-conversion or bit-selection error shows up as a wrong count of high clocks. The time between interrupt rises separates a correct period count from an off-by-one one. Skipped writes show that the old sample is held, and paired writes show that the later sample wins. Control words with and without bit 16, including the on and off words, separate the pin update from the sample path.

// File: rtl/pwm_audio_pkg.sv
// Shared field positions of the audio sample register.
// Assumes a 32-bit register word with a 16-bit sample in the low half.
package pwm_audio_pkg;
    localparam int REG_W      = 32;
    localparam int SMP_W      = 16;
    localparam int BIT_CTL_EN = 16;  // control-update on write, ready on read
    localparam int BIT_GAIN   = 20;
    localparam int BIT_SHDN_N = 21;
endpackage

// File: rtl/pwm_audio_rate.sv
// Sample-rate divider: pulses o_tick for one clock every PERIOD clocks.
// Assumes PERIOD >= 2. The first pulse comes PERIOD clocks after reset.
module pwm_audio_rate #(
    parameter int PERIOD = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic o_tick
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign o_tick = (cnt_q == LAST);

    // Count 0 .. PERIOD-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (o_tick) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_audio_carrier.sv
// PWM carrier: compares a free-running PWM_W-bit counter with the top
// PWM_W bits of the offset-binary sample. The output is registered.
// Assumes i_sample is two's complement and PWM_W <= SMP_W.
module pwm_audio_carrier #(
    parameter int SMP_W = 16,
    parameter int PWM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] i_sample,
    output logic             o_pwm
);
    logic [SMP_W-1:0] offset_bin;
    logic [PWM_W-1:0] level;
    logic [PWM_W-1:0] ramp_q;

    // Inverting the sign bit turns signed into offset binary.
    always_comb begin
        offset_bin = i_sample ^ {1'b1, {(SMP_W-1){1'b0}}};
        level      = offset_bin[SMP_W-1 -: PWM_W];
    end

    // Free-running ramp and compare register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_q <= '0;
            o_pwm  <= 1'b0;
        end else begin
            ramp_q <= ramp_q + 1'b1;
            o_pwm  <= (ramp_q < level);
        end
    end
endmodule

// File: rtl/pwm_audio_ctl.sv
// PWM audio sample controller top. It holds one queued sample and one
// playing sample. At each period boundary the queued sample moves into
// play and the ready interrupt rises. Writes with the control-enable bit
// set also load the amplifier gain and shutdown pins.
// Assumes one-cycle write strobes and combinational read decode upstream.
module pwm_audio_ctl #(
    parameter int CYCLES_PER_SAMPLE = 10000,
    parameter int PWM_W             = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_wr,
    input  logic [31:0] i_wdata,
    output logic [31:0] o_rdata,
    output logic        o_irq,
    output logic        o_pwm,
    output logic        o_gain,
    output logic        o_shutdown_n
);
    import pwm_audio_pkg::*;

    logic             smp_tick;
    logic [SMP_W-1:0] queued_q;
    logic             queued_full_q;
    logic [SMP_W-1:0] playing_q;
    logic             gain_q;
    logic             shdn_n_q;

    pwm_audio_rate #(.PERIOD(CYCLES_PER_SAMPLE)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .o_tick (smp_tick)
    );

    // Sample queue: a boundary moves the queued sample into play; a write refills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            queued_q      <= '0;
            queued_full_q <= 1'b0;
            playing_q     <= '0;
        end else begin
            if (smp_tick) begin
                if (queued_full_q) playing_q <= queued_q;
                queued_full_q <= 1'b0;
            end
            if (i_wr) begin
                queued_q      <= i_wdata[SMP_W-1:0];
                queued_full_q <= 1'b1;
            end
        end
    end

    // Amplifier control pins: loaded only by writes with the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q   <= 1'b0;
            shdn_n_q <= 1'b0;
        end else if (i_wr && i_wdata[BIT_CTL_EN]) begin
            gain_q   <= i_wdata[BIT_GAIN];
            shdn_n_q <= i_wdata[BIT_SHDN_N];
        end
    end

    pwm_audio_carrier #(.SMP_W(SMP_W), .PWM_W(PWM_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_sample (playing_q),
        .o_pwm    (o_pwm)
    );

    // Read word assembly and pin outputs.
    always_comb begin
        o_rdata                 = '0;
        o_rdata[SMP_W-1:0]      = queued_q;
        o_rdata[BIT_CTL_EN]     = ~queued_full_q;
        o_rdata[BIT_GAIN]       = gain_q;
        o_rdata[BIT_SHDN_N]     = shdn_n_q;
        o_irq                   = ~queued_full_q;
        o_gain                  = gain_q;
        o_shutdown_n            = shdn_n_q;
    end
endmodule

// File: rtl/pwm_audio_ctl_chk.sv
// Property checker for pwm_audio_ctl, attached by bind below.
// Assumes the rate tick is exposed as smp_tick inside the top.
module pwm_audio_ctl_chk #(
    parameter int CYCLES_PER_SAMPLE = 10000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        i_wr,
    input logic [31:0] i_wdata,
    input logic        o_irq,
    input logic        o_gain,
    input logic        o_shutdown_n,
    input logic        smp_tick
);
    localparam int GAP_W = $clog2(CYCLES_PER_SAMPLE) + 1;
    logic [GAP_W-1:0] gap_q;

    // Count clocks since reset or since the last period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_q <= '0;
        else if (smp_tick) gap_q <= '0;
        else               gap_q <= gap_q + 1'b1;
    end

    assert_period_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> (gap_q == GAP_W'(CYCLES_PER_SAMPLE - 1)));

    assert_write_clears_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        i_wr |=> !o_irq);

    assert_ctl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_wr && i_wdata[16]) |=> (o_gain == $past(i_wdata[20]))
                                 && (o_shutdown_n == $past(i_wdata[21])));

    assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_wr && !i_wdata[16]) |=> ($stable(o_gain) && $stable(o_shutdown_n)));

    assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_irq && !i_wr) |=> o_irq);
endmodule

bind pwm_audio_ctl pwm_audio_ctl_chk #(.CYCLES_PER_SAMPLE(CYCLES_PER_SAMPLE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_wr         (i_wr),
    .i_wdata      (i_wdata),
    .o_irq        (o_irq),
    .o_gain       (o_gain),
    .o_shutdown_n (o_shutdown_n),
    .smp_tick     (smp_tick)
);

// File: tb/pwm_audio_ctl_bench.sv
// Bench for pwm_audio_ctl with a 3-bit carrier and a 40-cycle sample period.
module pwm_audio_ctl_bench;
    localparam int PER = 40;
    localparam int PW  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_wr = 1'b0;
    logic [31:0] i_wdata = '0;
    logic [31:0] o_rdata;
    logic        o_irq, o_pwm, o_gain, o_shutdown_n;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwm_audio_ctl #(.CYCLES_PER_SAMPLE(PER), .PWM_W(PW)) u_pwm_audio_ctl (
        .clk(clk), .rst_n(rst_n), .i_wr(i_wr), .i_wdata(i_wdata),
        .o_rdata(o_rdata), .o_irq(o_irq), .o_pwm(o_pwm),
        .o_gain(o_gain), .o_shutdown_n(o_shutdown_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        i_wr = 1'b1; i_wdata = d;
        @(negedge clk);
        i_wr = 1'b0; i_wdata = '0;
    endtask

    task automatic wait_irq();
        while (!o_irq) @(negedge clk);
    endtask

    // Expected level: top PW bits of the sample with the sign bit inverted.
    function automatic int lvl(input logic [15:0] s);
        logic [15:0] ob;
        ob = s ^ 16'h8000;
        return int'(ob >> (16 - PW));
    endfunction

    task automatic duty(output int hi);
        hi = 0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < (1 << PW); c++) begin
            @(negedge clk);
            if (o_pwm) hi++;
        end
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] smp [0:8];
        int hi, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", o_rdata, 32'h0001_0000);
        check("R1 pins", {o_irq, o_gain, o_shutdown_n}, 32'b100);

        // R3 / R4 write clears ready, readback of sample
        wr(32'h0000_1234);
        check("R3 irq low", o_irq, 0);
        check("R4 readback", o_rdata, 32'h0000_1234);
        check("R6 pins kept", {o_gain, o_shutdown_n}, 0);

        // R2 period between interrupt rises
        wait_irq();
        check("R4 ready bit", o_rdata[16], 1);
        for (int k = 0; k < 9; k++) smp[k] = 16'((((k % 8) ^ 4) << 13) | (k * 16'h0137));
        wr({16'h0, smp[0]});
        n = 1;
        while (!o_irq) begin @(negedge clk); n++; end
        check("R2 period", n, PER);

        // R7 sweep of all duty levels, signs and varied low bits
        for (int k = 0; k < 8; k++) begin
            wr({16'h0, smp[k + 1]});
            duty(hi);
            check($sformatf("R7 level k=%0d", k), hi, lvl(smp[k]));
            wait_irq();
        end

        // R8 skip a write: old sample repeats, irq stays up
        duty(hi);
        check("R8 held sample", hi, lvl(smp[8]));
        check("R8 irq held", o_irq, 1);
        repeat (PER) @(negedge clk);
        check("R8 irq still", o_irq, 1);

        // R9 two writes in one period: the second plays
        wait_irq();
        wr(32'h0000_0000);
        wr(32'h0000_E000);
        wait_irq();
        duty(hi);
        check("R9 second wins", hi, lvl(16'hE000));

        // R5 / R6 amplifier control
        wr(32'h0031_0000);
        check("R5 on", {o_gain, o_shutdown_n}, 2'b11);
        check("R4 ctl readback", o_rdata, 32'h0030_0000);
        wr(32'h0000_7FFF);
        check("R6 no E keeps pins", {o_gain, o_shutdown_n}, 2'b11);
        wr(32'h0011_0000);
        check("R5 gain only", {o_gain, o_shutdown_n}, 2'b10);
        wr(32'h0021_0000);
        check("R5 shdn only", {o_gain, o_shutdown_n}, 2'b01);
        wr(32'h0030_0000);
        check("R6 bits ignored", {o_gain, o_shutdown_n}, 2'b01);
        wr(32'h0001_0000);
        check("R5 off", {o_gain, o_shutdown_n}, 2'b00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule